// File: doc/BRIEF.md
# GPIO port with interrupt detection

This block is a 32-pin general-purpose I/O port that sits on a simple register bus. The bus has an address, a write enable, write data and read data that is decoded in the same cycle. Software sets each pin to one of three roles: general input, general output, or interrupt source. For an output pin, the port drives the value held in the output register and raises that pin's output enable.

Every pin input first passes through a two-flop synchroniser. The synchronised level is what software reads back and what the detector watches. An interrupt pin can watch for a high or a low level, or for an edge. An edge pin can react to one direction only, or to both directions. A level pin's status follows the pin and is not latched. An edge pin's status stays set until software writes a one to the clear register.

Each pin has an enable bit. The enable can be written directly, or bits can be set one at a time by writing ones to a separate set-enable register. One registered interrupt line carries the OR, over all pins, of status AND enable.

Top module: `pinbank_port`

## Requirements
- R1: After reset, `pinOe`, `pinOut` and `irq` are 0, and every register offset reads 0. After reset all pins are general inputs, all enables are off and all status bits are clear.
- R2: Writes to these offsets are read back unchanged:
  - 0x00, role select, where 1 = interrupt pin.
  - 0x04, direction, where 1 = output.
  - 0x08, output data.
  - 0x18, enable, where 1 = enabled.
  - 0x20, polarity, where 1 = active low or falling edge.
  - 0x24, detect kind, where 1 = edge and 0 = level.
  - 0x4C, both-edge.

  Offsets 0x28 and 0x40 read 0 and ignore writes. Offsets 0x14 and 0x1C read 0. Any offset that is not listed reads 0.
- R3: `pinOe[i]` is 1 exactly when role bit i is 0 and direction bit i is 1. `pinOut` equals the output data AND `pinOe`.
- R4: Offset 0x0C returns the synchronised pin levels. A change on `pinIn` set up before clock edge k reads back after edge k+1.
- R5: For an interrupt pin in level mode, status bit i (offset 0x10) equals the synchronised pin XOR polarity bit i. It is not latched, and writes to the clear register do not affect it.
- R6: For an interrupt pin in edge mode with both-edge 0, polarity 0 sets status on a rising edge and polarity 1 sets it on a falling edge. Status then stays at 1 until it is cleared.
- R7: For an edge-mode pin with both-edge bit 1, either transition sets status.
- R8: Writing to 0x14 clears the status bits written as 1. Bits written as 0 have no effect. If an edge arrives in the same cycle as its clear, status stays set.
- R9: Writing to 0x1C sets the enable bits written as 1 and leaves the other enable bits unchanged.
- R10: `irq` is the registered OR over all pins of status AND enable. When a pin change is set up before edge k, the status of an edge pin reads 1 after edge k+2, and `irq` rises after edge k+3.
- R11: A pin whose role bit is 0 reads status 0 and never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write strobe for the current address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the current address, combinational |
| pinIn | input | 32 | Asynchronous pin levels |
| pinOut | output | 32 | Output levels, zero on pins that are not driven |
| pinOe | output | 32 | Output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets a clear write that lands in the same cycle as a fresh edge. A design that gives the clear priority would silently drop that event. The bench checks that level-mode status drops when the pin returns and is not affected by clears; a design that latched level status would keep `irq` stuck. It counts the exact cycle in which status and `irq` move, which exposes a missing or extra synchroniser stage. It also checks that a zero bit written to either strobe register changes nothing, and that general pins never reach `irq`. A long random phase then compares every output and every register read against a cycle-level model. In that phase role, polarity, detect kind and enables change while the pins are toggling.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam logic [7:0] OFF_ROLE   = 8'h00;
  localparam logic [7:0] OFF_DIR    = 8'h04;
  localparam logic [7:0] OFF_OUT    = 8'h08;
  localparam logic [7:0] OFF_IN     = 8'h0C;
  localparam logic [7:0] OFF_STAT   = 8'h10;
  localparam logic [7:0] OFF_CLR    = 8'h14;
  localparam logic [7:0] OFF_EN     = 8'h18;
  localparam logic [7:0] OFF_EN_SET = 8'h1C;
  localparam logic [7:0] OFF_POL    = 8'h20;
  localparam logic [7:0] OFF_KIND   = 8'h24;
  localparam logic [7:0] OFF_BOTH   = 8'h4C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ROLE, SEL_DIR, SEL_OUT, SEL_IN, SEL_STAT,
    SEL_EN, SEL_POL, SEL_KIND, SEL_BOTH
  } regSel_e;

  typedef struct packed {
    logic wrRole;
    logic wrDir;
    logic wrOut;
    logic wrEn;
    logic wrPol;
    logic wrKind;
    logic wrBoth;
    logic clrStat;
    logic setEn;
  } strobes_t;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobes_t          stb,
  output regSel_e           rdSel
);
  localparam int OFF_W = 8;
  logic [OFF_W-1:0] off;

  assign off = OFF_W'(busAddr);

  always_comb begin
    stb   = '0;
    rdSel = SEL_NONE;
    unique case (off)
      OFF_ROLE:   begin rdSel = SEL_ROLE; stb.wrRole = busWe; end
      OFF_DIR:    begin rdSel = SEL_DIR;  stb.wrDir  = busWe; end
      OFF_OUT:    begin rdSel = SEL_OUT;  stb.wrOut  = busWe; end
      OFF_IN:     rdSel = SEL_IN;
      OFF_STAT:   rdSel = SEL_STAT;
      OFF_CLR:    stb.clrStat = busWe;
      OFF_EN:     begin rdSel = SEL_EN;   stb.wrEn   = busWe; end
      OFF_EN_SET: stb.setEn = busWe;
      OFF_POL:    begin rdSel = SEL_POL;  stb.wrPol  = busWe; end
      OFF_KIND:   begin rdSel = SEL_KIND; stb.wrKind = busWe; end
      OFF_BOTH:   begin rdSel = SEL_BOTH; stb.wrBoth = busWe; end
      default:    rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/pinbank_dp.sv
module pinbank_dp
  import pinbank_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  regSel_e          rdSel,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic             irq
);
  logic [WIDTH-1:0] roleR, dirR, outR, enR, polR, kindR, bothR;
  logic [WIDTH-1:0] statR, prevR, syncd;
  logic [WIDTH-1:0] rise, fall, edgeHit, levelOn, clrBits, statNext;
  logic             irqR;

  pinbank_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(syncd)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      roleR <= '0; dirR <= '0; outR <= '0; enR <= '0;
      polR  <= '0; kindR <= '0; bothR <= '0;
    end else begin
      if (stb.wrRole) roleR <= busWdata;
      if (stb.wrDir)  dirR  <= busWdata;
      if (stb.wrOut)  outR  <= busWdata;
      if (stb.wrPol)  polR  <= busWdata;
      if (stb.wrKind) kindR <= busWdata;
      if (stb.wrBoth) bothR <= busWdata;
      if (stb.wrEn)       enR <= busWdata;
      else if (stb.setEn) enR <= enR | busWdata;
    end
  end

  // detection
  assign rise    = syncd & ~prevR;
  assign fall    = ~syncd & prevR;
  assign edgeHit = (bothR & (rise | fall)) | (~bothR & ~polR & rise) | (~bothR & polR & fall);
  assign levelOn = syncd ^ polR;
  assign clrBits = stb.clrStat ? busWdata : '0;
  assign statNext = roleR & ((kindR & ((statR & ~clrBits) | edgeHit)) | (~kindR & levelOn));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevR <= '0;
      statR <= '0;
      irqR  <= 1'b0;
    end else begin
      prevR <= syncd;
      statR <= statNext;
      irqR  <= |(statR & enR);
    end
  end

  assign irq    = irqR;
  assign pinOe  = ~roleR & dirR;
  assign pinOut = outR & pinOe;

  always_comb begin
    unique case (rdSel)
      SEL_ROLE: busRdata = roleR;
      SEL_DIR:  busRdata = dirR;
      SEL_OUT:  busRdata = outR;
      SEL_IN:   busRdata = syncd;
      SEL_STAT: busRdata = statR;
      SEL_EN:   busRdata = enR;
      SEL_POL:  busRdata = polR;
      SEL_KIND: busRdata = kindR;
      SEL_BOTH: busRdata = bothR;
      default:  busRdata = '0;
    endcase
  end

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(statR) & ~statR) & $past(roleR & kindR) & ~$past(clrBits)) == '0)); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrStat |=> ((statR & $past(busWdata & ~edgeHit & kindR)) == '0)); // R8
  AST_SET_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.setEn |=> ((enR & $past(busWdata)) == $past(busWdata))); // R9
  AST_GENERAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((statR & ~$past(roleR)) == '0)); // R11
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irqR |-> $past(|(statR & enR))); // R10
endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
  import pinbank_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [WIDTH-1:0]  busWdata,
  output logic [WIDTH-1:0]  busRdata,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  output logic              irq
);
  strobes_t stb;
  regSel_e  rdSel;

  pinbank_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr), .busWe(busWe), .stb(stb), .rdSel(rdSel)
  );

  pinbank_dp #(.WIDTH(WIDTH), .SYNC_STAGES(2)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdSel(rdSel), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );
endmodule

// File: tb/sim_pinbank_port.sv
module sim_pinbank_port;
  logic        clk = 0;
  logic        rstN = 0;
  logic [7:0]  busAddr = 0;
  logic        busWe = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = 0;
  logic [31:0] pinOut, pinOe;
  logic        irq;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  pinbank_port u0 (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irq(irq));

  always #5 clk = ~clk;

  // cycle-level reference built from the requirements
  logic [31:0] mS1, mS2, mPrev, mStat, mRole, mDir, mOut, mEn, mPol, mKind, mBoth;
  logic        mIrq;

  function automatic logic [31:0] nextStat();
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      logic up, dn, hit, clr;
      up  = mS2[i] && !mPrev[i];
      dn  = !mS2[i] && mPrev[i];
      hit = mBoth[i] ? (up || dn) : (mPol[i] ? dn : up);
      clr = busWe && busAddr == 8'h14 && busWdata[i];
      if (!mRole[i])      r[i] = 1'b0;
      else if (!mKind[i]) r[i] = mS2[i] ^ mPol[i];
      else                r[i] = hit || (mStat[i] && !clr);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      {mS1, mS2, mPrev, mStat, mRole, mDir, mOut, mEn, mPol, mKind, mBoth} <= '0;
      mIrq <= 0;
    end else begin
      mS1 <= pinIn; mS2 <= mS1; mPrev <= mS2;
      mStat <= nextStat();
      mIrq <= |(mStat & mEn);
      if (busWe) case (busAddr)
        8'h00: mRole <= busWdata;
        8'h04: mDir  <= busWdata;
        8'h08: mOut  <= busWdata;
        8'h18: mEn   <= busWdata;
        8'h1C: mEn   <= mEn | busWdata;
        8'h20: mPol  <= busWdata;
        8'h24: mKind <= busWdata;
        8'h4C: mBoth <= busWdata;
        default: ;
      endcase
    end
  end

  function automatic logic [31:0] expRead(logic [7:0] a);
    case (a)
      8'h00: return mRole;  8'h04: return mDir;  8'h08: return mOut;
      8'h0C: return mS2;    8'h10: return mStat; 8'h18: return mEn;
      8'h20: return mPol;   8'h24: return mKind; 8'h4C: return mBoth;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1;
    @(negedge clk);
    busWe = 0; busWdata = 0;
  endtask

  task automatic rdChk(string req, logic [7:0] a, logic [31:0] exp);
    busAddr = a; #1;
    chk(req, busRdata, exp);
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  localparam logic [7:0] OFFS [14] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                       8'h1C, 8'h20, 8'h24, 8'h28, 8'h40, 8'h4C, 8'h30};

  initial begin
    void'($urandom(32'd20240611));
    waitN(4);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pinOe", pinOe, 0);
    chk("R1 pinOut", pinOut, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    for (int i = 0; i < 14; i++) rdChk("R1 reg", OFFS[i], 0);

    // R2 readback, R3 drive
    wr(8'h04, 32'hA5A5_A5A5);
    wr(8'h00, 32'h0000_FF00);
    wr(8'h08, 32'hFFFF_0000);
    rdChk("R2 dir", 8'h04, 32'hA5A5_A5A5);
    rdChk("R2 role", 8'h00, 32'h0000_FF00);
    rdChk("R2 out", 8'h08, 32'hFFFF_0000);
    chk("R3 pinOe", pinOe, 32'hA5A5_00A5);
    chk("R3 pinOut", pinOut, 32'hA5A5_0000);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rdChk("R2 filter ignored", 8'h28, 0);
    rdChk("R2 select ignored", 8'h40, 0);
    rdChk("R2 clear reads 0", 8'h14, 0);
    chk("R3 pinOut unchanged", pinOut, 32'hA5A5_0000);

    // R10 / R4 / R6 timing on pin 3, rising edge
    wr(8'h00, 32'h8);
    wr(8'h24, 32'h8);
    wr(8'h1C, 32'h8);
    wr(8'h14, 32'hFFFF_FFFF);
    pinIn[3] = 1;
    @(negedge clk);
    @(negedge clk);
    rdChk("R4 input two edges", 8'h0C, 32'h8);
    rdChk("R10 status not yet", 8'h10, 0);
    @(negedge clk);
    rdChk("R10 status after k+2", 8'h10, 32'h8);
    chk("R10 irq not yet", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R10 irq after k+3", {31'b0, irq}, 1);
    pinIn[3] = 0; waitN(4);
    rdChk("R6 sticky after fall", 8'h10, 32'h8);
    wr(8'h14, 32'h0);
    rdChk("R8 zero bits no effect", 8'h10, 32'h8);
    wr(8'h14, 32'h8);
    rdChk("R8 clear", 8'h10, 0);
    @(negedge clk);
    chk("R10 irq drops", {31'b0, irq}, 0);

    // R6 falling with polarity 1
    wr(8'h20, 32'h8);
    pinIn[3] = 1; waitN(4);
    rdChk("R6 rise ignored when low-active", 8'h10, 0);
    pinIn[3] = 0; waitN(4);
    rdChk("R6 falling edge", 8'h10, 32'h8);
    wr(8'h14, 32'h8);

    // R7 both edges
    wr(8'h4C, 32'h8);
    pinIn[3] = 1; waitN(4);
    rdChk("R7 rise", 8'h10, 32'h8);
    wr(8'h14, 32'h8);
    rdChk("R7 cleared", 8'h10, 0);
    pinIn[3] = 0; waitN(4);
    rdChk("R7 fall", 8'h10, 32'h8);
    wr(8'h14, 32'h8);

    // R8 edge in the same cycle as clear
    pinIn[3] = 1;
    @(negedge clk);
    @(negedge clk);
    wr(8'h14, 32'h8);
    rdChk("R8 edge beats clear", 8'h10, 32'h8);
    wr(8'h14, 32'h8);
    rdChk("R8 clear after collision", 8'h10, 0);

    // R5 level mode on pin 4
    wr(8'h00, 32'h18);
    pinIn[4] = 1; waitN(4);
    rdChk("R5 level high", 8'h10, 32'h10);
    wr(8'h14, 32'h10);
    rdChk("R5 clear ignored", 8'h10, 32'h10);
    pinIn[4] = 0; waitN(4);
    rdChk("R5 not latched", 8'h10, 0);
    wr(8'h20, 32'h18);
    waitN(2);
    rdChk("R5 active low", 8'h10, 32'h10);

    // R9 enables
    wr(8'h18, 32'h0);
    waitN(2);
    rdChk("R9 enable cleared", 8'h18, 0);
    chk("R10 irq masked", {31'b0, irq}, 0);
    wr(8'h1C, 32'h10);
    rdChk("R9 set enable", 8'h18, 32'h10);
    wr(8'h1C, 32'h0);
    rdChk("R9 zero bits keep", 8'h18, 32'h10);
    @(negedge clk);
    chk("R10 irq on enable", {31'b0, irq}, 1);

    // R11 general pin
    wr(8'h18, 32'h80);
    pinIn[7] = 1; waitN(4);
    pinIn[7] = 0; waitN(4);
    rdChk("R11 general status", 8'h10, 32'h10);
    chk("R11 irq quiet", {31'b0, irq}, 0);

    // random phase against the reference
    for (int c = 0; c < 4000; c++) begin
      chk("R3 pinOe rnd", pinOe, ~mRole & mDir);
      chk("R3 pinOut rnd", pinOut, mOut & ~mRole & mDir);
      chk("R10 irq rnd", {31'b0, irq}, {31'b0, mIrq});
      if (!busWe) chk("R2 read rnd", busRdata, expRead(busAddr));
      pinIn = pinIn ^ ($urandom & $urandom & $urandom);
      busAddr = OFFS[$urandom % 14];
      busWe = ($urandom % 5) == 0;
      busWdata = $urandom;
      @(negedge clk); #1;
    end
    busWe = 0;
    finishRun();
  end
endmodule